// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Host Interface

This block is the host-facing digital logic of a multichannel converter that samples all of its channels at the same instant. A host drives active-low chip-select, read and write strobes plus a convert-start line and a shutdown line. All of these are asynchronous to the system clock, so the block resynchronises them. A small configuration register is loaded from the low nibble of the data bus. A sequencer decides when a convert-start rising edge is honoured, and a fixed-length timer stands in for the conversion time. An active-low end-of-conversion line tells the host when a fresh set of results is ready.

The per-channel sample values arrive on a flat parallel input port that stands in for the analog converters. They are frozen at the instant a conversion is accepted. They are then published to a result bank when the timer expires. The host reads the results one channel per read strobe. It receives a 16-bit word together with an output-enable that controls the tri-state drivers of the shared bus. Each result is shown either as offset binary or as two's complement.

Top module: `simsamp_if`

## Requirements
- R1: After reset `eoc_n` is 1, `bus_oe` is 0, `ref_ext_o` is 0, the output format is offset binary and the acquisition mode is 0.
- R2: A write-strobe rising edge while chip-select is low loads the configuration from `cfg_din`. In that nibble, bit 3 is the reference select (shown on `ref_ext_o`), bit 2 is the output format and bit 0 is the acquisition mode. A write with chip-select high, or with reserved bit 1 set, leaves the configuration unchanged.
- R3: An accepted convert-start rising edge drives `eoc_n` high within SYNC_STAGES+1 clock edges of the pin change, and `eoc_n` falls exactly SYNC_STAGES+1+CONV_CYCLES edges after it. The results then equal the samples present when the edge was accepted, even if `samples_i` changes later.
- R4: In mode 0 a rising edge is honoured only if convert-start fell while no conversion was running. A low that begins during a conversion does not start a new one when it ends.
- R5: In mode 1 a rising edge is honoured when convert-start was seen low for at least MIN_LOW_CYC consecutive clock samples, even if it fell during the previous conversion. A single-sample low pulse is rejected.
- R6: A convert-start rising edge while a conversion is running is ignored, and the running conversion keeps its completion time.
- R7: With chip-select and read low, `bus_oe` is 1 and `bus_out` carries the current channel's result. Each read rising edge with chip-select low moves to the next channel, and channel NCH-1 is followed by channel 0.
- R8: Chip-select may go high between reads without losing the channel position. A read rising edge while chip-select is high does not advance it.
- R9: `bus_oe` is 0 whenever read or chip-select is high.
- R10: With format bit set, each result is the offset-binary code with its most significant bit inverted.
- R11: Each completed conversion returns the readout to channel 0.
- R12: While shutdown is high, a running conversion is abandoned with `eoc_n` high and no convert-start edge is honoured. The configuration survives a shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| convst | input | 1 | Convert-start, rising edge starts a conversion |
| pwrdn | input | 1 | Shutdown, active high |
| cfg_din | input | 4 | Low nibble of the bus input path, configuration data |
| samples_i | input | NCH*DW | Per-channel sample values, channel c in bits c*DW+DW-1 down to c*DW |
| eoc_n | output | 1 | End of conversion, active low |
| bus_out | output | DW | Bus data to be driven by the tri-state pads |
| bus_oe | output | 1 | Bus output enable for the tri-state pads |
| ref_ext_o | output | 1 | Configured reference select, 1 for external |

## Verification
A corrupted channel pointer shows up on the first word read after a strobe, as the wrong channel or a missed wrap, about four clocks after read falls. A wrong sequencer state appears on `eoc_n`. A missed or spurious start shows up within a few clocks of the convert-start edge. A miscounted timer moves the falling edge of `eoc_n` away from its exact expected cycle. A configuration bit that is lost or loaded by mistake is visible at once on `ref_ext_o`, or on the most significant bit of the next word read.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic ref_ext;
    logic twos;
    logic auto_acq;
  } cfg_t;

  function automatic logic [15:0] fmt_word(input logic [15:0] v, input logic twos);
    return twos ? {~v[15], v[14:0]} : v;
  endfunction
endpackage

// File: rtl/simsamp_sync.sv
module simsamp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) st[0] <= RST_VAL;
      else     st[0] <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) st <= {STAGES{RST_VAL}};
      else     st <= {st[STAGES-2:0], d_i};
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq #(
  parameter int CONV_CYCLES = 150,
  parameter int MIN_LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cv_s,
  input  logic pwrdn_s,
  input  logic auto_acq,
  output logic start_o,
  output logic done_o,
  output logic eoc_n
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int LW = $clog2(MIN_LOW_CYC + 1);

  logic          cv_q, busy, armed;
  logic [CW-1:0] cnt;
  logic [LW-1:0] low_cnt;

  wire cv_rise = cv_s & ~cv_q;
  wire cv_fall = ~cv_s & cv_q;
  wire ok_m0   = ~auto_acq & armed;
  wire ok_m1   = auto_acq & (low_cnt >= LW'(MIN_LOW_CYC));

  assign start_o = cv_rise & ~busy & ~pwrdn_s & (ok_m0 | ok_m1);
  assign done_o  = busy & (cnt == '0) & ~pwrdn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q    <= 1'b1;
      busy    <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      low_cnt <= '0;
      eoc_n   <= 1'b1;
    end else begin
      cv_q <= cv_s;
      if (cv_s)                            low_cnt <= '0;
      else if (low_cnt < LW'(MIN_LOW_CYC)) low_cnt <= low_cnt + 1'b1;

      if (pwrdn_s) begin
        busy  <= 1'b0;
        armed <= 1'b0;
        eoc_n <= 1'b1;
      end else if (start_o) begin
        busy  <= 1'b1;
        armed <= 1'b0;
        cnt   <= CW'(CONV_CYCLES - 1);
        eoc_n <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) begin
          busy  <= 1'b0;
          eoc_n <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (cv_fall) begin
        armed <= 1'b1;
      end
    end
  end

  p_eoc_high_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> eoc_n);
  p_eoc_after_conv_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> $past(busy));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(CONV_CYCLES - 1)));
  p_shdn_idle_r12: assert property (@(posedge clk) disable iff (rst)
    pwrdn_s |=> (!busy && eoc_n));
endmodule

// File: rtl/simsamp_bank.sv
module simsamp_bank
  import simsamp_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [NCH*DW-1:0] samples_i,
  input  logic              rd_s,
  input  logic              cs_s,
  input  logic              twos,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe
);
  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [DW-1:0] snap [NCH];
  logic [DW-1:0] bank [NCH];
  logic [PW-1:0] ptr;
  logic          rd_q, cs_q;

  wire adv   = rd_s & ~rd_q & ~cs_q;
  wire drive = ~cs_s & ~rd_s;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (start_i) snap[c] <= samples_i[c*DW +: DW];
      if (done_i)  bank[c] <= snap[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      rd_q    <= 1'b1;
      cs_q    <= 1'b1;
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      rd_q   <= rd_s;
      cs_q   <= cs_s;
      bus_oe <= drive;
      bus_out <= drive ? fmt_word(bank[ptr], twos) : '0;
      if (done_i)                      ptr <= '0;
      else if (adv && ptr == PW'(NCH - 1)) ptr <= '0;
      else if (adv)                    ptr <= ptr + 1'b1;
    end
  end

  p_ptr_range_r7: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(NCH - 1));
  p_ptr_clear_r11: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (ptr == '0));
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!done_i && cs_q) |=> $stable(ptr));
endmodule

// File: rtl/simsamp_if.sv
module simsamp_if
  import simsamp_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 150,
  parameter int MIN_LOW_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              convst,
  input  logic              pwrdn,
  input  logic [CFG_W-1:0]  cfg_din,
  input  logic [NCH*DW-1:0] samples_i,
  output logic              eoc_n,
  output logic [DW-1:0]     bus_out,
  output logic              bus_oe,
  output logic              ref_ext_o
);
  localparam int SW = 5 + CFG_W;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 4'b1111, {CFG_W{1'b0}}};

  logic [SW-1:0]    sync_q;
  logic             pwrdn_s, cv_s, wr_s, rd_s, cs_s;
  logic [CFG_W-1:0] din_s;
  logic             wr_q, cs_q, start, done;
  cfg_t             cfg;

  simsamp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({pwrdn, convst, wr_n, rd_n, cs_n, cfg_din}),
    .q_o (sync_q)
  );
  assign {pwrdn_s, cv_s, wr_s, rd_s, cs_s, din_s} = sync_q;

  wire cfg_we = wr_s & ~wr_q & ~cs_q & ~din_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      cs_q <= 1'b1;
      cfg  <= '0;
    end else begin
      wr_q <= wr_s;
      cs_q <= cs_s;
      if (cfg_we) cfg <= '{ref_ext: din_s[3], twos: din_s[2], auto_acq: din_s[0]};
    end
  end
  assign ref_ext_o = cfg.ref_ext;

  simsamp_seq #(.CONV_CYCLES(CONV_CYCLES), .MIN_LOW_CYC(MIN_LOW_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cv_s     (cv_s),
    .pwrdn_s  (pwrdn_s),
    .auto_acq (cfg.auto_acq),
    .start_o  (start),
    .done_o   (done),
    .eoc_n    (eoc_n)
  );

  simsamp_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .done_i    (done),
    .samples_i (samples_i),
    .rd_s      (rd_s),
    .cs_s      (cs_s),
    .twos      (cfg.twos),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
  );

  p_cfg_write_only_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg != $past(cfg)) |-> $past(cfg_we));
  p_oe_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> !bus_oe);
endmodule

// File: tb/simsamp_if_tb.sv
module simsamp_if_tb;
  localparam int NCH = 8;
  localparam int DW = 16;
  localparam int SYNC = 2;
  localparam int CONV = 150;
  localparam int LAT = SYNC + 1 + CONV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, convst = 1'b1, pwrdn = 1'b0;
  logic [3:0] cfg_din = '0;
  logic [NCH*DW-1:0] samples = '0;
  logic eoc_n, bus_oe, ref_ext_o;
  logic [DW-1:0] bus_out;
  logic [DW-1:0] exp_smp [NCH];
  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  simsamp_if #(.NCH(NCH), .DW(DW), .SYNC_STAGES(SYNC), .CONV_CYCLES(CONV), .MIN_LOW_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .convst(convst),
    .pwrdn(pwrdn), .cfg_din(cfg_din), .samples_i(samples), .eoc_n(eoc_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .ref_ext_o(ref_ext_o)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_samples(int seed);
    for (int c = 0; c < NCH; c++) begin
      exp_smp[c] = 16'((seed * 40503 + c * 7919 + 4660) ^ (c << 12));
      samples[c*DW +: DW] = exp_smp[c];
    end
  endtask

  task automatic write_cfg(logic [3:0] v, logic csv);
    cs_n = csv; cfg_din = v; tick(2);
    wr_n = 1'b0; tick(4);
    wr_n = 1'b1; tick(4);
    cs_n = 1'b1; cfg_din = '0; tick(2);
  endtask

  // Start a conversion, glitch convst inside it if asked, check the latency (R3, R6)
  task automatic conv(int lowc, int glitch_at, int seed, string req);
    int n = 0;
    load_samples(seed);
    convst = 1'b0; tick(lowc);
    convst = 1'b1;
    while (n < 400) begin
      @(negedge clk); n++;
      if (n == SYNC + 1) chk({req, " R3 eoc high after start"}, eoc_n, 1);
      if (n == SYNC + 2) samples = ~samples;
      if (n == glitch_at) convst = 1'b0;
      if (n == glitch_at + 4) convst = 1'b1;
      if (n > SYNC + 1 && eoc_n == 1'b0) break;
    end
    chk({req, " R3 latency"}, n, LAT);
  endtask

  task automatic read_chk(int ch, bit twos, bit toggle, string req);
    logic [DW-1:0] e = twos ? {~exp_smp[ch][DW-1], exp_smp[ch][DW-2:0]} : exp_smp[ch];
    cs_n = 1'b0; rd_n = 1'b0; tick(4);
    chk({req, " R7 oe while reading"}, bus_oe, 1);
    chk({req, " R7 data"}, bus_out, e);
    rd_n = 1'b1; tick(4);
    chk({req, " R9 oe off with read high"}, bus_oe, 0);
    if (toggle) begin cs_n = 1'b1; tick(3); end
  endtask

  task automatic wait_eoc();
    int n = 0;
    while (eoc_n !== 1'b0 && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic late_fall(bit accept, string req);
    convst = 1'b0; tick(4); convst = 1'b1; tick(50);
    convst = 1'b0;
    wait_eoc(); tick(10);
    convst = 1'b1; tick(8);
    chk(req, eoc_n, accept ? 1 : 0);
    if (accept) wait_eoc();
  endtask

  task automatic t_reset();
    chk("R1 eoc_n after reset", eoc_n, 1);
    chk("R1 bus_oe after reset", bus_oe, 0);
    chk("R1 ref_ext after reset", ref_ext_o, 0);
  endtask

  task automatic t_basic();
    conv(4, -1, 1, "basic");
    for (int c = 0; c < NCH; c++) read_chk(c, 0, 0, "R7 sequential");
    read_chk(0, 0, 0, "R7 wrap to channel 0");
    cs_n = 1'b1; tick(3);
  endtask

  task automatic t_cs_toggle();
    conv(4, -1, 2, "cs");
    read_chk(0, 0, 1, "R8 first");
    cs_n = 1'b1; rd_n = 1'b0; tick(4);
    chk("R9 oe off with cs high", bus_oe, 0);
    rd_n = 1'b1; tick(4);
    read_chk(1, 0, 1, "R8 no advance with cs high");
    read_chk(2, 0, 1, "R8 third");
  endtask

  task automatic t_ptr_reset();
    conv(4, -1, 3, "ptr");
    read_chk(0, 0, 1, "R11 new conversion restarts at 0");
  endtask

  task automatic t_cfg();
    write_cfg(4'hC, 1'b0);
    chk("R2 ref select loaded", ref_ext_o, 1);
    conv(4, -1, 4, "cfg");
    read_chk(0, 1, 1, "R10 two's complement ch0");
    read_chk(1, 1, 1, "R10 two's complement ch1");
    write_cfg(4'h3, 1'b0);
    chk("R2 reserved bit write rejected ref", ref_ext_o, 1);
    conv(4, -1, 5, "cfg2");
    read_chk(0, 1, 1, "R2 reserved bit write rejected format");
    write_cfg(4'h0, 1'b1);
    chk("R2 write with cs high ignored", ref_ext_o, 1);
    write_cfg(4'h0, 1'b0);
    chk("R2 clear", ref_ext_o, 0);
  endtask

  task automatic t_mode0();
    late_fall(0, "R4 fall during conversion rejected in mode 0");
    conv(4, -1, 6, "R4 mode 0 normal");
  endtask

  task automatic t_mode1();
    write_cfg(4'h1, 1'b0);
    convst = 1'b0; tick(1); convst = 1'b1; tick(8);
    chk("R5 one-sample low pulse rejected", eoc_n, 0);
    conv(2, -1, 7, "R5 two-sample low accepted");
    late_fall(1, "R5 fall during conversion accepted in mode 1");
    conv(4, 50, 8, "R6 rise during conversion ignored");
    read_chk(0, 0, 1, "R6 results intact");
    write_cfg(4'h0, 1'b0);
  endtask

  task automatic t_shdn();
    write_cfg(4'hC, 1'b0);
    convst = 1'b0; tick(4); convst = 1'b1; tick(50);
    pwrdn = 1'b1; tick(5);
    chk("R12 eoc high in shutdown", eoc_n, 1);
    tick(200);
    chk("R12 conversion abandoned", eoc_n, 1);
    convst = 1'b0; tick(4); convst = 1'b1; tick(8);
    chk("R12 start ignored in shutdown", eoc_n, 1);
    pwrdn = 1'b0; tick(6);
    chk("R12 ref select retained", ref_ext_o, 1);
    conv(4, -1, 9, "R12 after shutdown");
    read_chk(0, 1, 1, "R12 format retained");
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    t_reset();
    t_basic();
    t_cs_toggle();
    t_ptr_reset();
    t_cfg();
    t_mode0();
    t_mode1();
    t_shdn();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule